// File: doc/BRIEF.md
# Y-extended saturating divider

This block is a sequential integer divider for a processor execute stage. A one-cycle start pulse hands it the operands together with a two-bit mode and a flag-request bit. It then works for a fixed number of cycles, one quotient bit per cycle, and finishes with a single-cycle done pulse.

In the two narrow modes the 64-bit dividend is built from a 32-bit Y value and the low word of operand A. The divisor is the low word of operand B. A quotient that does not fit in 32 bits is clamped to a fixed saturation value. In the two wide modes all 64 bits of A are divided by all 64 bits of B, and Y takes no part.

A divisor of zero ends the operation at once. It raises a fault in place of a write. When flags are requested, the block also produces negative, zero, overflow and carry flags for the narrow result. The overflow flag marks a clamp.

Top module: `div_ysat`

## Requirements
- R1: Mode 0 (unsigned narrow) writes the quotient of the unsigned 64-bit value {y_in, opa[31:0]} divided by opb[31:0], zero-extended to 64 bits. opa[63:32] and opb[63:32] have no effect.
- R2: In mode 0, a quotient of 2^32 or more is replaced by 0x00000000FFFFFFFF.
- R3: Mode 1 (signed narrow) divides the signed 64-bit value {y_in, opa[31:0]} by the signed opb[31:0]. The quotient is truncated toward zero and sign-extended to 64 bits.
- R4: In mode 1, a quotient above 2^31-1 becomes 0x000000007FFFFFFF, and a quotient below -2^31 becomes 0xFFFFFFFF80000000.
- R5: Mode 2 (unsigned wide) and mode 3 (signed wide) divide all 64 bits of opa by all 64 bits of opb, and y_in has no effect. Nothing saturates in these modes: mode 3 with -2^63 / -1 gives 0x8000000000000000.
- R6: A zero divisor (opb[31:0] in modes 0 and 1, all of opb in modes 2 and 3) raises dz_fault together with done one cycle after start is taken. wr_en stays low, and result and flags keep their previous values.
- R7: When set_flags was high at start, flags_vld pulses with done. flags is {N, Z, V, C} (bit 3 down to bit 0). In modes 0 and 1, N = result[31], Z = (result[31:0] == 0), V = saturation occurred, and C = 0. In modes 2 and 3 all four bits are 0. With set_flags low, flags_vld stays low and flags reads zero after the operation.
- R8: busy is high from the cycle after start is taken until done. done is a one-cycle pulse, 65 clock edges after the edge that takes start when the divisor is nonzero.
- R9: A start pulse while busy is high is ignored. It neither produces an extra done nor changes the running operation's result.
- R10: After reset, busy, done, wr_en, dz_fault and flags_vld are low, and result and flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| mode | input | 2 | 0 unsigned narrow, 1 signed narrow, 2 unsigned wide, 3 signed wide |
| set_flags | input | 1 | Request flag output for this operation |
| y_in | input | 32 | Upper dividend word for narrow modes |
| opa | input | 64 | First operand (dividend) |
| opb | input | 64 | Second operand (divisor) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_en | output | 1 | Result is valid for write-back (with done) |
| dz_fault | output | 1 | Division-by-zero fault (with done) |
| result | output | 64 | Quotient after sign fix and saturation |
| flags_vld | output | 1 | Flags are valid (with done) |
| flags | output | 4 | {N, Z, V, C} |

## Verification
The assertions check the handshake on every cycle: done lasts one cycle, a taken start raises busy, and a fault never comes with a write. They also check that carry is never set when flags are valid, that every completed write follows exactly the full iteration count, and that the partial remainder inside the core stays below the divisor. The values themselves can only be shown by the bench's scenarios. These are the exact quotients, the two saturation boundaries on either side of -2^31 and 2^31-1, the bits of Y and of the operands that must be ignored, the retained result after a fault, and a start pulse dropped in the middle of a busy operation.

// File: rtl/div_pkg.sv
package div_pkg;
  localparam int DW = 64;
  localparam int HW = 32;

  typedef enum logic [1:0] {
    DM_U32 = 2'd0,
    DM_S32 = 2'd1,
    DM_U64 = 2'd2,
    DM_S64 = 2'd3
  } div_mode_e;

  typedef struct packed {
    logic [DW-1:0] res;
    logic          sat;
  } fix_t;

  function automatic logic mode_is_wide(div_mode_e m);
    return m[1];
  endfunction

  function automatic logic mode_is_signed(div_mode_e m);
    return m[0];
  endfunction

  // two's complement magnitude of a signed value, as unsigned
  function automatic logic [DW-1:0] magnitude(logic [DW-1:0] v, logic sgn);
    return (sgn && v[DW-1]) ? (~v + 1'b1) : v;
  endfunction

  // apply quotient sign and clamp narrow results
  function automatic fix_t fix_quotient(div_mode_e m, logic neg, logic [DW-1:0] q);
    fix_t f;
    f.sat = 1'b0;
    f.res = q;
    case (m)
      DM_U32: begin
        if (|q[DW-1:HW]) begin
          f.sat = 1'b1;
          f.res = {{HW{1'b0}}, {HW{1'b1}}};
        end else begin
          f.res = {{HW{1'b0}}, q[HW-1:0]};
        end
      end
      DM_S32: begin
        if (!neg) begin
          if (|q[DW-1:HW-1]) begin
            f.sat = 1'b1;
            f.res = {{(HW+1){1'b0}}, {(HW-1){1'b1}}};
          end else begin
            f.res = q;
          end
        end else begin
          if (q > {{(HW-1){1'b0}}, 1'b1, {(HW){1'b0}}} >> 1) begin
            f.sat = 1'b1;
            f.res = {{(HW+1){1'b1}}, {(HW-1){1'b0}}};
          end else begin
            f.res = ~q + 1'b1;
          end
        end
      end
      DM_U64: f.res = q;
      default: f.res = neg ? (~q + 1'b1) : q;
    endcase
    return f;
  endfunction
endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep
  import div_pkg::*;
(
  input  div_mode_e     mode,
  input  logic [HW-1:0] y_in,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  output logic [DW-1:0] dvd_mag,
  output logic [DW-1:0] dvs_mag,
  output logic          q_neg,
  output logic          dvs_zero
);
  logic [DW-1:0] dvd_raw;
  logic [DW-1:0] dvs_raw;
  logic          sgn;

  always_comb begin
    sgn = mode_is_signed(mode);
    if (mode_is_wide(mode)) begin
      dvd_raw = opa;
      dvs_raw = opb;
    end else begin
      dvd_raw = {y_in, opa[HW-1:0]};
      dvs_raw = sgn ? {{HW{opb[HW-1]}}, opb[HW-1:0]} : {{HW{1'b0}}, opb[HW-1:0]};
    end
    dvd_mag  = magnitude(dvd_raw, sgn);
    dvs_mag  = magnitude(dvs_raw, sgn);
    q_neg    = sgn && (dvd_raw[DW-1] ^ dvs_raw[DW-1]);
    dvs_zero = (dvs_raw == '0);
  end
endmodule

// File: rtl/div_restore_core.sv
module div_restore_core #(
  parameter int W = 64,
  localparam int CW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] dvd,
  input  logic [W-1:0] dvs,
  output logic         running,
  output logic         last,
  output logic [W-1:0] quo
);
  logic [W-1:0]  rem_q, quo_q, dvs_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic [W:0]    trial, diff;
  logic          fits;

  always_comb begin
    trial = {rem_q, quo_q[W-1]};
    diff  = trial - {1'b0, dvs_q};
    fits  = !diff[W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      rem_q <= '0;
      quo_q <= dvd;
      dvs_q <= dvs;
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (run_q) begin
      rem_q <= fits ? diff[W-1:0] : trial[W-1:0];
      quo_q <= {quo_q[W-2:0], fits};
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CW'(W-1)) run_q <= 1'b0;
    end
  end

  assign running = run_q;
  assign last    = run_q && (cnt_q == CW'(W-1));
  assign quo     = quo_q;

  // partial remainder never reaches the divisor while iterating
  AST_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (rem_q < dvs_q)); // R1
endmodule

// File: rtl/div_result_fix.sv
module div_result_fix
  import div_pkg::*;
(
  input  div_mode_e     mode,
  input  logic          q_neg,
  input  logic [DW-1:0] quo,
  output logic [DW-1:0] res,
  output logic          sat,
  output logic [3:0]    flg
);
  fix_t f;
  always_comb begin
    f   = fix_quotient(mode, q_neg, quo);
    res = f.res;
    sat = f.sat;
    if (mode_is_wide(mode)) flg = 4'b0000;
    else flg = {f.res[HW-1], (f.res[HW-1:0] == '0), f.sat, 1'b0};
  end
endmodule

// File: rtl/div_ysat.sv
module div_ysat
  import div_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic          set_flags,
  input  logic [31:0]   y_in,
  input  logic [63:0]   opa,
  input  logic [63:0]   opb,
  output logic          busy,
  output logic          done,
  output logic          wr_en,
  output logic          dz_fault,
  output logic [63:0]   result,
  output logic          flags_vld,
  output logic [3:0]    flags
);
  localparam int ITER = DW;
  localparam int LW   = $clog2(ITER) + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} st_e;

  st_e           state_q;
  div_mode_e     mode_in, mode_q;
  logic          flg_q, neg_q, dz_q;
  logic [DW-1:0] dvd_mag, dvs_mag;
  logic          q_neg, dvs_zero;
  logic          accept, core_load, core_run, core_last;
  logic [DW-1:0] core_quo;
  logic [DW-1:0] fix_res;
  logic          fix_sat;
  logic [3:0]    fix_flg;
  logic [LW-1:0] run_len;

  assign mode_in   = div_mode_e'(mode);
  assign accept    = start && (state_q == ST_IDLE);
  assign core_load = accept && !dvs_zero;
  assign busy      = (state_q != ST_IDLE);

  div_operand_prep u_prep (
    .mode(mode_in), .y_in(y_in), .opa(opa), .opb(opb),
    .dvd_mag(dvd_mag), .dvs_mag(dvs_mag), .q_neg(q_neg), .dvs_zero(dvs_zero)
  );

  div_restore_core #(.W(DW)) u_core (
    .clk(clk), .rst_n(rst_n), .load(core_load), .dvd(dvd_mag), .dvs(dvs_mag),
    .running(core_run), .last(core_last), .quo(core_quo)
  );

  div_result_fix u_fix (
    .mode(mode_q), .q_neg(neg_q), .quo(core_quo),
    .res(fix_res), .sat(fix_sat), .flg(fix_flg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      mode_q    <= DM_U32;
      flg_q     <= 1'b0;
      neg_q     <= 1'b0;
      dz_q      <= 1'b0;
      done      <= 1'b0;
      wr_en     <= 1'b0;
      dz_fault  <= 1'b0;
      flags_vld <= 1'b0;
      result    <= '0;
      flags     <= '0;
      run_len   <= '0;
    end else begin
      done      <= 1'b0;
      wr_en     <= 1'b0;
      dz_fault  <= 1'b0;
      flags_vld <= 1'b0;
      case (state_q)
        ST_IDLE: if (accept) begin
          mode_q  <= mode_in;
          flg_q   <= set_flags;
          neg_q   <= q_neg;
          dz_q    <= dvs_zero;
          run_len <= '0;
          state_q <= dvs_zero ? ST_FIN : ST_RUN;
        end
        ST_RUN: begin
          run_len <= run_len + 1'b1;
          if (core_last) state_q <= ST_FIN;
        end
        default: begin
          done    <= 1'b1;
          state_q <= ST_IDLE;
          if (dz_q) begin
            dz_fault <= 1'b1;
          end else begin
            wr_en     <= 1'b1;
            result    <= fix_res;
            flags_vld <= flg_q;
            flags     <= flg_q ? fix_flg : 4'b0000;
          end
        end
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R8
  AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    dz_fault |-> (done && !wr_en && !flags_vld)); // R6
  AST_CARRY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    flags_vld |-> !flags[0]); // R7
  AST_FULL_ITER: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (run_len == LW'(ITER))); // R8
  AST_CORE_IDLE_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !core_run); // R9
endmodule

// File: tb/div_ysat_bench.sv
module div_ysat_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        set_flags = 1'b0;
  logic [31:0] y_in = '0;
  logic [63:0] opa = '0, opb = '0;
  logic        busy, done, wr_en, dz_fault, flags_vld;
  logic [63:0] result;
  logic [3:0]  flags;

  always #10 clk = ~clk; // 50 MHz

  div_ysat u_div_ysat (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .set_flags(set_flags),
    .y_in(y_in), .opa(opa), .opb(opb), .busy(busy), .done(done), .wr_en(wr_en),
    .dz_fault(dz_fault), .result(result), .flags_vld(flags_vld), .flags(flags)
  );

  typedef struct {
    logic [63:0] res;
    logic        wr;
    logic        dz;
    logic        fv;
    logic [3:0]  fl;
    int          lat;
    int          t0;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0, fails = 0, cyc = 0;
  logic [63:0] model_res = '0;
  logic [3:0]  model_fl = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [1:0] m, input logic sf, input logic [31:0] y,
                                 input logic [63:0] a, input logic [63:0] b, input string tag);
    exp_t e;
    logic [63:0] uq;
    longint sd, sv, sq;
    logic sat = 1'b0;
    e.dz = 1'b0;
    e.res = '0;
    e.tag = tag;
    case (m)
      2'd0: begin
        if (b[31:0] == 0) e.dz = 1'b1;
        else begin
          uq = {y, a[31:0]} / {32'd0, b[31:0]};
          if (uq > 64'hFFFF_FFFF) begin sat = 1'b1; e.res = 64'hFFFF_FFFF; end
          else e.res = uq;
        end
      end
      2'd1: begin
        sd = longint'({y, a[31:0]});
        sv = longint'(int'(b[31:0]));
        if (sv == 0) e.dz = 1'b1;
        else if (sd == 64'sh8000_0000_0000_0000 && sv == -1) begin
          sat = 1'b1; e.res = 64'h7FFF_FFFF;
        end else begin
          sq = sd / sv;
          if (sq > 64'sd2147483647) begin sat = 1'b1; e.res = 64'h7FFF_FFFF; end
          else if (sq < -64'sd2147483648) begin sat = 1'b1; e.res = 64'hFFFF_FFFF_8000_0000; end
          else e.res = sq;
        end
      end
      2'd2: begin
        if (b == 0) e.dz = 1'b1;
        else e.res = a / b;
      end
      default: begin
        if (b == 0) e.dz = 1'b1;
        else if (a == 64'h8000_0000_0000_0000 && b == '1) e.res = a;
        else begin sq = longint'(a) / longint'(b); e.res = sq; end
      end
    endcase
    e.wr = !e.dz;
    e.fv = sf && !e.dz;
    if (e.dz) begin
      e.res = model_res;
      e.fl  = model_fl;
      e.lat = 1;
    end else begin
      e.fl = (sf && !m[1]) ? {e.res[31], e.res[31:0] == 0, sat, 1'b0} : 4'b0000;
      e.lat = 65;
      model_res = e.res;
      model_fl  = e.fl;
    end
    return e;
  endfunction

  task automatic run_op(input logic [1:0] m, input logic sf, input logic [31:0] y,
                        input logic [63:0] a, input logic [63:0] b, input string tag,
                        input bit poke);
    exp_t e;
    e = model(m, sf, y, a, b, tag);
    @(negedge clk);
    mode = m; set_flags = sf; y_in = y; opa = a; opb = b; start = 1'b1;
    e.t0 = cyc + 1;
    sb.push_back(e);
    @(negedge clk);
    start = 1'b0;
    mode = 2'd2; y_in = 32'hA5A5_A5A5; opa = '1; opb = 64'd3;
    chk(busy == 1'b1, "R8", "busy after start", {63'd0, busy}, 64'd1);
    if (poke) begin
      repeat (10) @(negedge clk);
      mode = 2'd0; opa = 64'd9; opb = 64'd1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: pops the scoreboard at every completion
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (done) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R9", "unexpected done", 64'd1, 64'd0);
        end else begin
          e = sb.pop_front();
          chk(result == e.res, e.tag, "result", result, e.res);
          chk(wr_en == e.wr && dz_fault == e.dz, e.tag, "wr/dz",
              {62'd0, wr_en, dz_fault}, {62'd0, e.wr, e.dz});
          chk(flags_vld == e.fv && flags == e.fl, "R7", {e.tag, " flags"},
              {59'd0, flags_vld, flags}, {59'd0, e.fv, e.fl});
          chk(cyc - e.t0 == e.lat, "R8", {e.tag, " latency"},
              64'(cyc - e.t0), 64'(e.lat));
        end
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R8", "done one cycle", {62'd0, done, busy}, 64'd0);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !wr_en && !dz_fault && !flags_vld, "R10", "ctrl after reset",
        {59'd0, busy, done, wr_en, dz_fault, flags_vld}, 64'd0);
    chk(result == 0 && flags == 0, "R10", "data after reset", result, 64'd0);

    run_op(2'd0, 1, 32'd0, 64'd100, 64'd7, "R1", 0);
    run_op(2'd0, 1, 32'd1, 64'd0, 64'd2, "R1", 0);
    run_op(2'd0, 1, 32'hDEAD_BEEF, 64'hFFFF_0000_0000_0000, 64'h1234_5678_0000_0003, "R1", 0);
    run_op(2'd0, 1, 32'd5, 64'd0, 64'd2, "R2", 0);
    run_op(2'd0, 1, 32'hFFFF_FFFF, 64'hFFFF_FFFF, 64'd1, "R2", 0);
    run_op(2'd1, 1, 32'hFFFF_FFFF, 64'hFFFF_FF9C, 64'd7, "R3", 0);
    run_op(2'd1, 1, 32'd0, 64'd3, 64'd7, "R3", 0);
    run_op(2'd1, 1, 32'hFFFF_FFFF, 64'h8000_0000, 64'd1, "R3", 0);
    run_op(2'd1, 1, 32'd0, 64'h7FFF_FFFF, 64'hFFFF_FFFF, "R3", 0);
    run_op(2'd1, 1, 32'd1, 64'd0, 64'd1, "R4", 0);
    run_op(2'd1, 1, 32'd1, 64'd0, 64'hFFFF_FFFF, "R4", 0);
    run_op(2'd1, 1, 32'hFFFF_FFFF, 64'h7FFF_FFFF, 64'd1, "R4", 0);
    run_op(2'd1, 1, 32'h8000_0000, 64'd0, 64'hFFFF_FFFF, "R4", 0);
    run_op(2'd2, 1, 32'hFFFF_FFFF, 64'hFEDC_BA98_7654_3210, 64'd3, "R5", 0);
    run_op(2'd3, 1, 32'd7, -64'd1000, 64'd3, "R5", 0);
    run_op(2'd3, 0, 32'd0, 64'h8000_0000_0000_0000, '1, "R5", 0);
    run_op(2'd0, 1, 32'd9, 64'd55, 64'hFFFF_0000_0000_0000, "R6", 0);
    run_op(2'd2, 1, 32'd9, 64'd55, 64'd0, "R6", 0);
    run_op(2'd0, 0, 32'd0, 64'd81, 64'd9, "R7", 0);
    run_op(2'd0, 1, 32'd0, 64'd1000, 64'd10, "R9", 1);
    repeat (80) @(negedge clk);
    chk(sb.size() == 0, "R9", "pending items", 64'(sb.size()), 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule